// File: doc/BRIEF.md
# Dual-Lane Dot-Product Accumulator

This block is a clocked multiply-accumulate engine for packed 16-bit data. Each 32-bit operand carries two signed halfwords. One operation forms two 16x16 signed products and then adds both of them to, or subtracts both of them from, one of several 64-bit accumulators. The issue port selects the lane pairing, the fractional (Q15) scaling and the clamping of the result to the signed 32-bit range. Every accumulator has a sticky overflow flag that records saturation events and the single fractional product that cannot be represented.

An operation takes two cycles. In the issue cycle both products are registered. In the next cycle the selected accumulator is rewritten, and `busy` is high during that cycle so that no second operation can start. A host port can write either 32-bit half of any accumulator, and a combinational read port shows both halves of any accumulator. Instruction decode happens outside this block.

Top module: `dual_mac_acc`

## Requirements
- R1: After reset every accumulator is zero, `ovfFlags` is zero and `busy` is low.
- R2: The block accepts an issue when `issueValid` is high and `busy` is low. `busy` is then high for exactly the next cycle, and the accumulator holds its new value after the following clock edge. `issueValid` has no effect while `busy` is high.
- R3: The accumulator value is the signed 64-bit number {hi, lo}. In straight pairing (`issueCross`=0) the two products are opA[15:0]*opB[15:0] and opA[31:16]*opB[31:16]. With `issueSub`=0 their sum is added, and the result wraps modulo 2^64 when saturation is off.
- R4: With `issueSub`=1 the sum of both products is subtracted from the accumulator.
- R5: In crossed pairing (`issueCross`=1) the two products are opA[15:0]*opB[31:16] and opA[31:16]*opB[15:0].
- R6: With `issueQ15`=1 each product is doubled before accumulation.
- R7: With `issueQ15`=1, a pair in which both halfwords are 0x8000 contributes 0x7FFFFFFF. It also sets bit N of `ovfFlags`, where N is the selected accumulator number.
- R8: With `issueSat`=1 (in either scaling mode) a result above 0x7FFFFFFF becomes 0x00000000_7FFFFFFF, and a result below -2^31 becomes 0xFFFFFFFF_80000000. Either clamp sets the flag bit of that accumulator. A result inside the range is stored unchanged and sets no flag.
- R9: Flag bits stay set until `ovfClear` is high at a clock edge, which zeroes them all. A flag set by a commit at that same edge still ends up set.
- R10: `wrHiEn` / `wrLoEn` write `wrData` into bits 63:32 / 31:0 of accumulator `wrAcc` at the clock edge. `rdHi`/`rdLo` show accumulator `rdAcc` combinationally.
- R11: When a commit and a host write hit the same accumulator at the same edge, the commit wins and the host write is dropped.
- R12: An operation changes only the accumulator it selects, and an accumulator with no commit and no host write holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Start an operation |
| issueSub | input | 1 | 1 = subtract products, 0 = add |
| issueCross | input | 1 | 1 = crossed lane pairing |
| issueQ15 | input | 1 | 1 = fractional doubling |
| issueSat | input | 1 | 1 = clamp result to 32-bit signed range |
| issueAcc | input | 2 | Target accumulator |
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand |
| busy | output | 1 | Commit in progress; issue is blocked |
| wrHiEn | input | 1 | Write upper half of `wrAcc` |
| wrLoEn | input | 1 | Write lower half of `wrAcc` |
| wrAcc | input | 2 | Accumulator for host writes |
| wrData | input | 32 | Host write data |
| rdAcc | input | 2 | Accumulator shown on the read port |
| rdHi | output | 32 | Bits 63:32 of the read accumulator |
| rdLo | output | 32 | Bits 31:0 of the read accumulator |
| ovfClear | input | 1 | Clear all overflow flags |
| ovfFlags | output | 4 | Sticky overflow flag per accumulator |

## Verification
A wrong product register, pairing choice or accumulator write shows up on `rdHi`/`rdLo` for the affected accumulator exactly one edge after the commit. A reference model compares the read port, `busy` and the flags after every clock, so such an error is reported in that same cycle. A stuck or stray flag bit shows on `ovfFlags` after the edge that should (or should not) have set it. A control error that lets an issue through during `busy` corrupts the target accumulator at the next edge, and that edge's comparison catches it.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capture;   // register products this edge
    logic commit;    // update accumulator this edge
    logic subtract;  // commit subtracts the product sum
    logic saturate;  // commit clamps to 32-bit signed
  } dmac_stb_t;
endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int NUM_ACC = 4,
  localparam int IDX_W = $clog2(NUM_ACC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             issueSub,
  input  logic             issueSat,
  input  logic [IDX_W-1:0] issueAcc,
  output dmac_stb_t        stb,
  output logic [IDX_W-1:0] accSel,
  output logic             busy
);
  logic             pending;
  logic             subQ;
  logic             satQ;
  logic [IDX_W-1:0] accQ;
  logic             take;

  assign take = issueValid && !pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      subQ    <= 1'b0;
      satQ    <= 1'b0;
      accQ    <= '0;
    end else begin
      pending <= take;
      if (take) begin
        subQ <= issueSub;
        satQ <= issueSat;
        accQ <= issueAcc;
      end
    end
  end

  always_comb begin
    stb.capture  = take;
    stb.commit   = pending;
    stb.subtract = subQ;
    stb.saturate = satQ;
  end

  assign accSel = accQ;
  assign busy   = pending;
endmodule

// File: rtl/dmac_dp.sv
module dmac_dp
  import dmac_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int NUM_ACC = 4,
  localparam int WORD_W = 2 * LANE_W,
  localparam int ACC_W  = 2 * WORD_W,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmac_stb_t         stb,
  input  logic [IDX_W-1:0]  accSel,
  input  logic              issueCross,
  input  logic              issueQ15,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              wrHiEn,
  input  logic              wrLoEn,
  input  logic [IDX_W-1:0]  wrAcc,
  input  logic [WORD_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdAcc,
  input  logic              ovfClear,
  output logic [WORD_W-1:0] rdHi,
  output logic [WORD_W-1:0] rdLo,
  output logic [NUM_ACC-1:0] ovfFlags
);
  localparam int LANES = 2;
  localparam logic signed [LANE_W-1:0] LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic signed [WORD_W-1:0] WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_HI = {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_LO = {{(ACC_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  logic signed [WORD_W-1:0] prodQ [LANES];
  logic [LANES-1:0]         minPair;
  logic                     minHitQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [LANE_W-1:0] aLane;
    logic signed [LANE_W-1:0] bLane;
    logic signed [WORD_W-1:0] rawProd;
    logic signed [WORD_W-1:0] scaled;

    assign aLane   = opA[g*LANE_W +: LANE_W];
    assign bLane   = issueCross ? opB[(LANES-1-g)*LANE_W +: LANE_W]
                                : opB[g*LANE_W +: LANE_W];
    assign rawProd = aLane * bLane;
    assign minPair[g] = issueQ15 && (aLane == LANE_MIN) && (bLane == LANE_MIN);

    always_comb begin
      if (!issueQ15)       scaled = rawProd;
      else if (minPair[g]) scaled = WORD_MAX;
      else                 scaled = rawProd <<< 1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            prodQ[g] <= '0;
      else if (stb.capture) prodQ[g] <= scaled;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            minHitQ <= 1'b0;
    else if (stb.capture) minHitQ <= |minPair;
  end

  // accumulator bank
  logic [WORD_W-1:0] accHi [NUM_ACC];
  logic [WORD_W-1:0] accLo [NUM_ACC];

  logic [ACC_W-1:0] accOld;
  logic [ACC_W-1:0] pairSum;
  logic [ACC_W-1:0] rawSum;
  logic [ACC_W-1:0] newVal;
  logic             clampHit;

  assign accOld  = {accHi[accSel], accLo[accSel]};
  assign pairSum = {{WORD_W{prodQ[0][WORD_W-1]}}, prodQ[0]}
                 + {{WORD_W{prodQ[1][WORD_W-1]}}, prodQ[1]};
  assign rawSum  = stb.subtract ? accOld - pairSum : accOld + pairSum;

  always_comb begin
    newVal   = rawSum;
    clampHit = 1'b0;
    if (stb.saturate) begin
      if ($signed(rawSum) > $signed(SAT_HI)) begin
        newVal   = SAT_HI;
        clampHit = 1'b1;
      end else if ($signed(rawSum) < $signed(SAT_LO)) begin
        newVal   = SAT_LO;
        clampHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_ACC; k++) begin
        accHi[k] <= '0;
        accLo[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NUM_ACC; k++) begin
        if (stb.commit && accSel == IDX_W'(k)) begin
          accHi[k] <= newVal[ACC_W-1:WORD_W];
          accLo[k] <= newVal[WORD_W-1:0];
        end else if (wrAcc == IDX_W'(k)) begin
          if (wrHiEn) accHi[k] <= wrData;
          if (wrLoEn) accLo[k] <= wrData;
        end
      end
    end
  end

  // sticky flags
  logic [NUM_ACC-1:0] flagSet;
  assign flagSet = (stb.commit && (minHitQ || clampHit))
                 ? (NUM_ACC'(1) << accSel) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlags <= '0;
    else       ovfFlags <= (ovfClear ? '0 : ovfFlags) | flagSet;
  end

  assign rdHi = accHi[rdAcc];
  assign rdLo = accLo[rdAcc];
endmodule

// File: rtl/dual_mac_acc.sv
module dual_mac_acc
  import dmac_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int NUM_ACC = 4,
  localparam int WORD_W = 2 * LANE_W,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic               issueSub,
  input  logic               issueCross,
  input  logic               issueQ15,
  input  logic               issueSat,
  input  logic [IDX_W-1:0]   issueAcc,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  output logic               busy,
  input  logic               wrHiEn,
  input  logic               wrLoEn,
  input  logic [IDX_W-1:0]   wrAcc,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [IDX_W-1:0]   rdAcc,
  output logic [WORD_W-1:0]  rdHi,
  output logic [WORD_W-1:0]  rdLo,
  input  logic               ovfClear,
  output logic [NUM_ACC-1:0] ovfFlags
);
  dmac_stb_t        stb;
  logic [IDX_W-1:0] accSel;

  dmac_ctrl #(.NUM_ACC(NUM_ACC)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueSub(issueSub),
    .issueSat(issueSat), .issueAcc(issueAcc), .stb(stb), .accSel(accSel),
    .busy(busy)
  );

  dmac_dp #(.LANE_W(LANE_W), .NUM_ACC(NUM_ACC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accSel(accSel),
    .issueCross(issueCross), .issueQ15(issueQ15), .opA(opA), .opB(opB),
    .wrHiEn(wrHiEn), .wrLoEn(wrLoEn), .wrAcc(wrAcc), .wrData(wrData),
    .rdAcc(rdAcc), .ovfClear(ovfClear), .rdHi(rdHi), .rdLo(rdLo),
    .ovfFlags(ovfFlags)
  );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int LANE_W  = 16,
  parameter int NUM_ACC = 4,
  localparam int WORD_W = 2 * LANE_W,
  localparam int IDX_W  = $clog2(NUM_ACC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               issueValid,
  input logic               busy,
  input logic               wrHiEn,
  input logic               wrLoEn,
  input logic [IDX_W-1:0]   rdAcc,
  input logic [WORD_W-1:0]  rdHi,
  input logic [WORD_W-1:0]  rdLo,
  input logic               ovfClear,
  input logic [NUM_ACC-1:0] ovfFlags
);
  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !busy |=> busy);

  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ovfClear |=> ((ovfFlags & $past(ovfFlags)) == $past(ovfFlags)));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfClear && !busy |=> ovfFlags == '0);

  // R7
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ((ovfFlags & ~$past(ovfFlags)) == '0));

  // R12
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!busy && !wrHiEn && !wrLoEn) && $stable(rdAcc)
      |-> $stable(rdHi) && $stable(rdLo));
endmodule

bind dual_mac_acc dmac_chk #(.LANE_W(LANE_W), .NUM_ACC(NUM_ACC)) u_chk (.*);

// File: tb/dual_mac_acc_tb.sv
`timescale 1ns/1ps
module dual_mac_acc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 0, issueSub = 0, issueCross = 0, issueQ15 = 0, issueSat = 0;
  logic [1:0]  issueAcc = 0;
  logic [31:0] opA = 0, opB = 0;
  logic        busy;
  logic        wrHiEn = 0, wrLoEn = 0;
  logic [1:0]  wrAcc = 0;
  logic [31:0] wrData = 0;
  logic [1:0]  rdAcc = 0;
  logic [31:0] rdHi, rdLo;
  logic        ovfClear = 0;
  logic [3:0]  ovfFlags;

  int    total = 0;
  int    bad = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  dual_mac_acc u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueSub(issueSub),
    .issueCross(issueCross), .issueQ15(issueQ15), .issueSat(issueSat),
    .issueAcc(issueAcc), .opA(opA), .opB(opB), .busy(busy),
    .wrHiEn(wrHiEn), .wrLoEn(wrLoEn), .wrAcc(wrAcc), .wrData(wrData),
    .rdAcc(rdAcc), .rdHi(rdHi), .rdLo(rdLo), .ovfClear(ovfClear),
    .ovfFlags(ovfFlags)
  );

  // behavioural reference
  longint mAcc [4];
  bit [3:0] mFlags;
  bit      mPend, mSub, mSat, mHit;
  int      mSel;
  longint  mP0, mP1;

  function automatic longint lanePrd(bit [15:0] a, bit [15:0] b, bit q, output bit hit);
    longint p;
    hit = 0;
    p = longint'($signed(a)) * longint'($signed(b));
    if (q) begin
      if (a == 16'h8000 && b == 16'h8000) begin p = 64'h7FFFFFFF; hit = 1; end
      else p = p * 2;
    end
    return p;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mAcc[i] = 0;
      mFlags = 0; mPend = 0;
    end else begin
      bit h0, h1, setF, cm;
      longint s;
      setF = 0; cm = mPend;
      if (mPend) begin
        s = mSub ? mAcc[mSel] - (mP0 + mP1) : mAcc[mSel] + (mP0 + mP1);
        if (mSat && s > 64'sh7FFFFFFF) begin s = 64'sh7FFFFFFF; setF = 1; end
        else if (mSat && s < -64'sh80000000) begin s = -64'sh80000000; setF = 1; end
        if (mHit) setF = 1;
        mAcc[mSel] = s;
      end
      if (!(cm && mSel == int'(wrAcc))) begin
        if (wrHiEn) mAcc[wrAcc][63:32] = wrData;
        if (wrLoEn) mAcc[wrAcc][31:0] = wrData;
      end
      if (ovfClear) mFlags = 0;
      if (cm && setF) mFlags[mSel] = 1'b1;
      if (issueValid && !mPend) begin
        mP0 = lanePrd(opA[15:0], issueCross ? opB[31:16] : opB[15:0], issueQ15, h0);
        mP1 = lanePrd(opA[31:16], issueCross ? opB[15:0] : opB[31:16], issueQ15, h1);
        mHit = h0 | h1; mSub = issueSub; mSat = issueSat; mSel = int'(issueAcc);
        mPend = 1;
      end else mPend = 0;
    end
  end

  // per-cycle comparison, away from the edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rstN) begin
        longint v;
        v = mAcc[rdAcc];
        total++;
        if (rdHi !== v[63:32] || rdLo !== v[31:0] || busy !== mPend || ovfFlags !== mFlags) begin
          bad++;
          $display("FAIL %s cycle model: acc%0d act=%h_%h busy=%b flags=%b exp=%h_%h busy=%b flags=%b",
                   curReq, rdAcc, rdHi, rdLo, busy, ovfFlags, v[63:32], v[31:0], mPend, mFlags);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doMac(bit [1:0] acc, bit sub, bit cr, bit q, bit sat, bit [31:0] a, bit [31:0] b);
    @(negedge clk);
    issueValid = 1; issueAcc = acc; issueSub = sub; issueCross = cr;
    issueQ15 = q; issueSat = sat; opA = a; opB = b;
    @(negedge clk);
    issueValid = 0;
    @(negedge clk);
  endtask

  task automatic readAcc(bit [1:0] acc);
    rdAcc = acc; #1;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      readAcc(2'(i));
      chk("R1 hi", rdHi, 0); chk("R1 lo", rdLo, 0);
    end
    chk("R1 flags", {28'd0, ovfFlags}, 0);
    chk("R1 busy", {31'd0, busy}, 0);

    curReq = "R3";
    doMac(0, 0, 0, 0, 0, 32'h0003_0002, 32'h0005_0004);
    readAcc(0); chk("R3 lo", rdLo, 23); chk("R3 hi", rdHi, 0);

    curReq = "R5";
    doMac(1, 0, 1, 0, 0, 32'h0003_0002, 32'h0005_0004);
    readAcc(1); chk("R5 lo", rdLo, 22);

    curReq = "R4";
    doMac(0, 1, 0, 0, 0, 32'h0003_0002, 32'h0005_0004);
    readAcc(0); chk("R4 lo zero", rdLo, 0);
    doMac(0, 1, 0, 0, 0, 32'h0003_0002, 32'h0005_0004);
    readAcc(0); chk("R4 hi", rdHi, 32'hFFFFFFFF); chk("R4 lo", rdLo, 32'hFFFFFFE9);

    curReq = "R6";
    doMac(2, 0, 0, 1, 0, 32'h4000_4000, 32'h4000_4000);
    readAcc(2); chk("R6 lo", rdLo, 32'h40000000); chk("R6 flags", {28'd0, ovfFlags}, 0);

    curReq = "R7";
    doMac(3, 0, 0, 1, 0, 32'h8000_0001, 32'h8000_0001);
    readAcc(3); chk("R7 lo", rdLo, 32'h80000001); chk("R7 hi", rdHi, 0);
    chk("R7 flags", {28'd0, ovfFlags}, 4'b1000);

    curReq = "R8";
    doMac(2, 0, 0, 1, 1, 32'h4000_4000, 32'h4000_4000);
    readAcc(2); chk("R8 high clamp lo", rdLo, 32'h7FFFFFFF); chk("R8 high clamp hi", rdHi, 0);
    chk("R8 flags", {28'd0, ovfFlags}, 4'b1100);

    curReq = "R10";
    @(negedge clk); wrAcc = 1; wrData = 32'hFFFFFFFF; wrHiEn = 1;
    @(negedge clk); wrHiEn = 0; wrData = 32'h80000000; wrLoEn = 1;
    @(negedge clk); wrLoEn = 0;
    readAcc(1); chk("R10 hi", rdHi, 32'hFFFFFFFF); chk("R10 lo", rdLo, 32'h80000000);

    curReq = "R8";
    doMac(1, 1, 0, 0, 1, 32'h0000_0001, 32'h0000_0001);
    readAcc(1); chk("R8 low clamp hi", rdHi, 32'hFFFFFFFF); chk("R8 low clamp lo", rdLo, 32'h80000000);
    chk("R8 flags low", {28'd0, ovfFlags}, 4'b1110);
    doMac(0, 0, 0, 0, 1, 32'h0000_0001, 32'h0000_0001);
    readAcc(0); chk("R8 in range lo", rdLo, 32'hFFFFFFEA);
    chk("R8 in range flags", {28'd0, ovfFlags}, 4'b1110);

    curReq = "R12";
    readAcc(3); chk("R12 acc3 kept", rdLo, 32'h80000001);

    curReq = "R9";
    @(negedge clk); ovfClear = 1;
    @(negedge clk); ovfClear = 0;
    chk("R9 cleared", {28'd0, ovfFlags}, 0);
    @(negedge clk);
    issueValid = 1; issueAcc = 3; issueSub = 0; issueCross = 0; issueQ15 = 1; issueSat = 0;
    opA = 32'h8000_0001; opB = 32'h8000_0001;
    @(negedge clk); issueValid = 0; ovfClear = 1;
    @(negedge clk); ovfClear = 0;
    chk("R9 set beats clear", {28'd0, ovfFlags}, 4'b1000);
    readAcc(3); chk("R7 carry hi", rdHi, 1); chk("R7 carry lo", rdLo, 2);
    repeat (3) @(negedge clk);
    chk("R9 sticky", {28'd0, ovfFlags}, 4'b1000);

    curReq = "R2";
    @(negedge clk);
    issueValid = 1; issueAcc = 0; issueSub = 0; issueCross = 0; issueQ15 = 0; issueSat = 0;
    opA = 32'h0000_0001; opB = 32'h0000_0001;
    @(negedge clk);
    chk("R2 busy", {31'd0, busy}, 1);
    opA = 32'h0064_0064; opB = 32'h0001_0001;
    @(negedge clk); issueValid = 0;
    chk("R2 busy drop", {31'd0, busy}, 0);
    readAcc(0); chk("R2 ignored issue", rdLo, 32'hFFFFFFEB);
    @(negedge clk);

    curReq = "R11";
    @(negedge clk);
    issueValid = 1; issueAcc = 0; opA = 32'h0000_0001; opB = 32'h0000_0001;
    @(negedge clk); issueValid = 0; wrAcc = 0; wrLoEn = 1; wrData = 32'h0000DEAD;
    @(negedge clk); wrLoEn = 0;
    readAcc(0); chk("R11 commit wins", rdLo, 32'hFFFFFFEC);

    curReq = "random";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      issueValid = 1'($urandom); issueSub = 1'($urandom); issueCross = 1'($urandom);
      issueQ15 = 1'($urandom); issueSat = 1'($urandom); issueAcc = 2'($urandom);
      opA = ($urandom % 4 == 0) ? 32'h8000_8000 : $urandom;
      opB = ($urandom % 4 == 0) ? 32'h8000_8000 : $urandom;
      wrHiEn = ($urandom % 8 == 0); wrLoEn = ($urandom % 8 == 0);
      wrAcc = 2'($urandom); wrData = $urandom;
      rdAcc = 2'($urandom); ovfClear = ($urandom % 16 == 0);
    end
    @(negedge clk);
    issueValid = 0; wrHiEn = 0; wrLoEn = 0; ovfClear = 0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule